// File: doc/BRIEF.md
# Coherent Cache Directory with Upstream Alias Check

This block is the tag and metadata directory of one slice of a set-associative, inclusive cache. A client presents a lookup carrying a set index, a tag, an operation kind (acquire from the upstream data cache, release from it, or snoop from below) and the upstream alias bits of the requester. The directory compares the tag against every way of the set. Two cycles after the lookup is accepted, it reports hit or miss, the hitting way and that way's metadata.

Each way records a two-bit permission state with four levels: invalid, read-only, write permission held by an upstream cache, and readable-writable here. Alongside the state it records a dirty bit, an upstream-holds flag, the upstream alias, a prefetched flag, a prefetch origin and an accessed flag. A physical line may be held upstream under one alias only. So an acquire that hits a line held upstream under a different alias produces a probe request for the old alias, and the directory then stores the new alias on its own. A release that misses breaks inclusion and is flagged. A separate write port installs a tag and full metadata into a chosen way.

Top module: `cdir_lookup`

## Requirements
- R1: After reset, every way of every set is invalid with all metadata zero, so any lookup misses; `res_valid` and `prb_valid` are low and `req_ready` is high.
- R2: A lookup accepted at a clock edge (`req_valid` and `req_ready` both high) produces exactly one result, with `res_valid` high in the cycle after the next edge. Results come back in acceptance order.
- R3: A lookup hits when a way of the set has a state other than invalid and a matching tag. `res_way` is that way's index and `res_meta` is its metadata. State codes: invalid 00, read-only 01, upstream-writable 10, local-writable 11. Metadata layout: [1:0] state, [2] dirty, [3] upstream-holds, [5:4] alias, [6] prefetched, [8:7] prefetch origin, [9] accessed.
- R4: A miss reports `res_hit`=0, `res_way`=0 and `res_meta`=0. A way whose tag matches but whose state is invalid does not hit.
- R5: A write (`wr_valid`) replaces the tag and the whole metadata of way `wr_way` in set `wr_set`. Lookups accepted at later edges see the new contents.
- R6: When a write and a lookup target the same set in the same cycle, `req_ready` is low and the write is performed first. A write to a different set does not lower `req_ready`.
- R7: Operation kinds are acquire 00, release 01 and snoop 10 (11 behaves as snoop). An acquire that hits a way with the upstream-holds bit set and a stored alias different from the request alias raises `prb_valid` together with its result. `prb_set`, `prb_tag` and `prb_alias` then carry the line and the stored alias, and `res_meta` shows the metadata as it was before the lookup. Without a probe, the three probe fields read zero.
- R8: After such a probe, the stored alias of that way becomes the acquire's alias and the other fields are unchanged. A lookup to the same set in the cycle right after the conflicting lookup is accepted is held off (`req_ready` low) until the alias is stored.
- R9: No probe is raised for a release or snoop, for an acquire whose alias equals the stored one, or for an acquire hitting a way whose upstream-holds bit is clear.
- R10: A release that misses raises `res_release_miss` with its result. A release that hits, and a miss of any other kind, does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_op | input | 2 | Operation kind (acquire/release/snoop) |
| req_set | input | IDX_W | Set index |
| req_tag | input | TAG_W | Tag to compare |
| req_alias | input | 2 | Upstream alias bits of the requester |
| wr_valid | input | 1 | Directory write request |
| wr_way | input | WAY_W | Way to write |
| wr_set | input | IDX_W | Set to write |
| wr_tag | input | TAG_W | Tag to install |
| wr_meta | input | META_W | Metadata to install |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_way | output | WAY_W | Hitting way |
| res_meta | output | META_W | Metadata of the hitting way |
| res_release_miss | output | 1 | Release missed (inclusion violated) |
| prb_valid | output | 1 | Probe for the stored alias required |
| prb_set | output | IDX_W | Set of the line to probe |
| prb_tag | output | TAG_W | Tag of the line to probe |
| prb_alias | output | 2 | Alias recorded before the acquire |

## Verification
The bound checker watches the timing contract on every cycle: a result appears only two edges after an acceptance, at most one way matches, a probe comes only with a hit and names an alias that differs from the request, a release-miss flag comes only with a miss, and a miss carries zeroed metadata. Only the bench scenarios can show that contents are right. They cover installing lines and reading them back per way, replacing the alias after a probe, the stalls for same-set writes and for the alias update, and the cases in which a probe must not be raised. A reference model in the bench predicts each result from the requirements.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

  localparam int ALIAS_W = 2;
  localparam int PSRC_W  = 2;

  typedef enum logic [1:0] {
    PERM_N  = 2'b00,
    PERM_B  = 2'b01,
    PERM_T  = 2'b10,
    PERM_TT = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    OP_ACQ = 2'b00,
    OP_REL = 2'b01,
    OP_SNP = 2'b10
  } op_e;

  // bit 0 at the bottom: state, dirty, upstream-holds, alias, prefetched, origin, accessed
  typedef struct packed {
    logic                accessed;
    logic [PSRC_W-1:0]   pf_src;
    logic                pf;
    logic [ALIAS_W-1:0]  alias_b;
    logic                clients;
    logic                dirty;
    perm_e               state;
  } line_meta_t;

  localparam int META_W = $bits(line_meta_t);

endpackage

// File: rtl/cdir_way_bank.sv
module cdir_way_bank
  import cdir_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_set,
  output logic [TAG_W-1:0]   rd_tag,
  output line_meta_t         rd_meta,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_set,
  input  logic [TAG_W-1:0]   wr_tag,
  input  line_meta_t         wr_meta,
  input  logic               fix_en,
  input  logic [IDX_W-1:0]   fix_set,
  input  logic [ALIAS_W-1:0] fix_alias
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem  [SETS];
  line_meta_t       meta_mem [SETS];

  // tag array: no reset, synchronous read, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_set] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_set];
  end

  // metadata: cleared on reset; a full write issued after the alias fix wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) meta_mem[s] <= '0;
      rd_meta <= '0;
    end else begin
      if (fix_en) meta_mem[fix_set].alias_b <= fix_alias;
      if (wr_en)  meta_mem[wr_set] <= wr_meta;
      if (rd_en)  rd_meta <= meta_mem[rd_set];
    end
  end

endmodule

// File: rtl/cdir_match.sv
module cdir_match
  import cdir_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int TAG_W = 12,
  parameter int WAY_W = 3
) (
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [TAG_W-1:0] way_tag  [WAYS],
  input  line_meta_t       way_meta [WAYS],
  output logic [WAYS-1:0]  hit_vec,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output line_meta_t       hit_meta
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = lk_valid && (way_meta[w].state != PERM_N) &&
                        (way_tag[w] == lk_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way  = '0;
    hit_meta = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_meta = hit_meta | way_meta[w];
      end
    end
  end

endmodule

// File: rtl/cdir_lookup.sv
module cdir_lookup
  import cdir_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int IDX_W = 4,
  parameter int TAG_W = 12,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [IDX_W-1:0]   req_set,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [ALIAS_W-1:0] req_alias,
  input  logic               wr_valid,
  input  logic [WAY_W-1:0]   wr_way,
  input  logic [IDX_W-1:0]   wr_set,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [META_W-1:0]  wr_meta,
  output logic               res_valid,
  output logic               res_hit,
  output logic [WAY_W-1:0]   res_way,
  output logic [META_W-1:0]  res_meta,
  output logic               res_release_miss,
  output logic               prb_valid,
  output logic [IDX_W-1:0]   prb_set,
  output logic [TAG_W-1:0]   prb_tag,
  output logic [ALIAS_W-1:0] prb_alias
);

  // stage 1: request captured, ways read
  logic               s1_valid;
  logic [1:0]         s1_op;
  logic [IDX_W-1:0]   s1_set;
  logic [TAG_W-1:0]   s1_tag;
  logic [ALIAS_W-1:0] s1_alias;

  logic [TAG_W-1:0] bank_tag  [WAYS];
  line_meta_t       bank_meta [WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  line_meta_t       hit_meta;
  logic             alias_fix;
  logic             accept;

  assign accept = req_valid && req_ready;

  // the write and the pending alias fix both go ahead of a same-set lookup
  assign req_ready = !(wr_valid && (wr_set == req_set)) &&
                     !(alias_fix && (s1_set == req_set));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_set   <= '0;
      s1_tag   <= '0;
      s1_alias <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_op    <= req_op;
        s1_set   <= req_set;
        s1_tag   <= req_tag;
        s1_alias <= req_alias;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cdir_way_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .rd_en    (accept),
      .rd_set   (req_set),
      .rd_tag   (bank_tag[w]),
      .rd_meta  (bank_meta[w]),
      .wr_en    (wr_valid && (wr_way == WAY_W'(w))),
      .wr_set   (wr_set),
      .wr_tag   (wr_tag),
      .wr_meta  (line_meta_t'(wr_meta)),
      .fix_en   (alias_fix && hit_vec[w]),
      .fix_set  (s1_set),
      .fix_alias(s1_alias)
    );
  end

  cdir_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .lk_valid(s1_valid),
    .lk_tag  (s1_tag),
    .way_tag (bank_tag),
    .way_meta(bank_meta),
    .hit_vec (hit_vec),
    .hit     (hit),
    .hit_way (hit_way),
    .hit_meta(hit_meta)
  );

  assign alias_fix = hit && (s1_op == OP_ACQ) && hit_meta.clients &&
                     (hit_meta.alias_b != s1_alias);

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid        <= 1'b0;
      res_hit          <= 1'b0;
      res_way          <= '0;
      res_meta         <= '0;
      res_release_miss <= 1'b0;
      prb_valid        <= 1'b0;
      prb_set          <= '0;
      prb_tag          <= '0;
      prb_alias        <= '0;
    end else begin
      res_valid        <= s1_valid;
      res_hit          <= hit;
      res_way          <= hit_way;
      res_meta         <= hit_meta;
      res_release_miss <= s1_valid && (s1_op == OP_REL) && !hit;
      prb_valid        <= alias_fix;
      prb_set          <= alias_fix ? s1_set : '0;
      prb_tag          <= alias_fix ? s1_tag : '0;
      prb_alias        <= alias_fix ? hit_meta.alias_b : '0;
    end
  end

endmodule

// File: rtl/cdir_lookup_chk.sv
module cdir_lookup_chk #(
  parameter int WAYS   = 8,
  parameter int WAY_W  = 3,
  parameter int META_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_alias,
  input logic              res_valid,
  input logic              res_hit,
  input logic [WAY_W-1:0]  res_way,
  input logic [META_W-1:0] res_meta,
  input logic              res_release_miss,
  input logic              prb_valid,
  input logic [1:0]        prb_alias,
  input logic [WAYS-1:0]   hit_vec
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!res_valid && !prb_valid));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid && req_ready, 2));

  a_r3_single_way: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  a_r3_hit_not_invalid: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (res_meta[1:0] != 2'b00));

  a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_meta == '0 && res_way == '0));

  a_r7_probe_on_hit: assert property (@(posedge clk) disable iff (rst)
    prb_valid |-> (res_valid && res_hit && res_meta[3]));

  a_r7_probe_alias_differs: assert property (@(posedge clk) disable iff (rst)
    prb_valid |-> (prb_alias != $past(req_alias, 2) && prb_alias == res_meta[5:4]));

  a_r10_release_miss: assert property (@(posedge clk) disable iff (rst)
    res_release_miss |-> (res_valid && !res_hit && !prb_valid));

endmodule

bind cdir_lookup cdir_lookup_chk #(
  .WAYS  (WAYS),
  .WAY_W (WAY_W),
  .META_W(cdir_pkg::META_W)
) u_chk (.*);

// File: tb/cdir_lookup_bench.sv
module cdir_lookup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 8;
  localparam int IDX_W = 4;
  localparam int TAG_W = 12;
  localparam int SETS  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [IDX_W-1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [1:0] req_alias = '0;
  logic wr_valid = 1'b0;
  logic [2:0] wr_way = '0;
  logic [IDX_W-1:0] wr_set = '0;
  logic [TAG_W-1:0] wr_tag = '0;
  logic [9:0] wr_meta = '0;
  logic res_valid, res_hit, res_release_miss, prb_valid;
  logic [2:0] res_way;
  logic [9:0] res_meta;
  logic [IDX_W-1:0] prb_set;
  logic [TAG_W-1:0] prb_tag;
  logic [1:0] prb_alias;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdir_lookup #(.WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_cdir_lookup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_set(req_set), .req_tag(req_tag), .req_alias(req_alias),
    .wr_valid(wr_valid), .wr_way(wr_way), .wr_set(wr_set), .wr_tag(wr_tag),
    .wr_meta(wr_meta), .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
    .res_meta(res_meta), .res_release_miss(res_release_miss), .prb_valid(prb_valid),
    .prb_set(prb_set), .prb_tag(prb_tag), .prb_alias(prb_alias));

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [33:0] vec;
    string       rq;
  } exp_t;
  exp_t exp_q[$];

  // reference model of the directory contents
  logic [TAG_W-1:0] m_tag  [SETS][WAYS];
  logic [9:0]       m_meta [SETS][WAYS];

  function automatic logic [9:0] mk(input logic [1:0] st, input logic dty,
      input logic cl, input logic [1:0] al, input logic pf, input logic [1:0] src,
      input logic acc);
    return {acc, src, pf, al, cl, dty, st};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // compute the result the requirements call for, then update the model
  function automatic logic [33:0] predict(input logic [1:0] op, input int s,
      input logic [TAG_W-1:0] t, input logic [1:0] al);
    logic h = 0; logic [2:0] w = 0; logic [9:0] m = 0;
    logic pv = 0; logic [1:0] pa = 0; logic rm;
    for (int i = 0; i < WAYS; i++)
      if (m_meta[s][i][1:0] != 2'b00 && m_tag[s][i] == t) begin
        h = 1; w = 3'(i); m = m_meta[s][i];
      end
    if (h && op == 2'b00 && m[3] && m[5:4] != al) begin
      pv = 1; pa = m[5:4];
      m_meta[s][w][5:4] = al;
    end
    rm = (op == 2'b01) && !h;
    return {h, w, m, pv, pa, pv ? 4'(s) : 4'd0, pv ? t : 12'd0, rm};
  endfunction

  task automatic do_write(input int s, input int w, input logic [TAG_W-1:0] t,
                          input logic [9:0] m);
    m_tag[s][w] = t; m_meta[s][w] = m;
    @(negedge clk);
    wr_valid = 1; wr_set = 4'(s); wr_way = 3'(w); wr_tag = t; wr_meta = m;
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic do_lookup(input logic [1:0] op, input int s, input logic [TAG_W-1:0] t,
                           input logic [1:0] al, input string rq, output bit stalled);
    exp_t e;
    e.vec = predict(op, s, t, al); e.rq = rq;
    exp_q.push_back(e);
    stalled = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_set = 4'(s); req_tag = t; req_alias = al;
    #1;
    while (!req_ready) begin stalled = 1; @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic look(input logic [1:0] op, input int s, input logic [TAG_W-1:0] t,
                      input logic [1:0] al, input string rq);
    bit st;
    do_lookup(op, s, t, al, rq, st);
  endtask

  // write and lookup offered in the same cycle
  task automatic both(input int ws, input int ls, input logic [TAG_W-1:0] t,
                      input logic [9:0] m, input bit exp_rdy);
    exp_t e; bit rdy0;
    m_tag[ws][0] = t; m_meta[ws][0] = m;
    e.vec = predict(2'b10, ls, t, 2'b00); e.rq = "R6";
    exp_q.push_back(e);
    @(negedge clk);
    wr_valid = 1; wr_set = 4'(ws); wr_way = 3'd0; wr_tag = t; wr_meta = m;
    req_valid = 1; req_op = 2'b10; req_set = 4'(ls); req_tag = t; req_alias = 0;
    #1; rdy0 = req_ready;
    chk(rdy0 == exp_rdy, "R6", "req_ready with concurrent write", 64'(rdy0), 64'(exp_rdy));
    @(posedge clk); #1;
    wr_valid = 0;
    if (!rdy0) begin
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
    end
    req_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      logic [33:0] act;
      act = {res_hit, res_way, res_meta, prb_valid, prb_alias, prb_set, prb_tag,
             res_release_miss};
      if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected result", 64'(act), 64'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(act == e.vec, e.rq, "result {hit,way,meta,prb,alias,set,tag,rmiss}",
            64'(act), 64'(e.vec));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit st;
    logic [31:0] lcg = 32'h1234_5678;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_tag[s][w] = '0; m_meta[s][w] = '0; end

    repeat (3) @(posedge clk);
    #1; rst = 0;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(res_valid == 0, "R1", "res_valid after reset", 64'(res_valid), 0);
    chk(prb_valid == 0, "R1", "prb_valid after reset", 64'(prb_valid), 0);
    chk(req_ready == 1, "R1", "req_ready after reset", 64'(req_ready), 1);

    // R1/R4: empty directory misses; tag zero too
    look(2'b00, 3, 12'h005, 2'd1, "R1");
    look(2'b10, 0, 12'h000, 2'd0, "R4");
    // R10: release miss on empty directory
    look(2'b01, 7, 12'h0AA, 2'd0, "R10");

    // R5/R3: fill set 2, way 5 left invalid with a matching tag
    for (int w = 0; w < WAYS; w++)
      do_write(2, w, 12'h100 + 12'(w),
               mk((w == 5) ? 2'b00 : 2'(w % 4 == 0 ? 1 : w % 4), w[0], 1'b0,
                  2'(w), w[1], 2'(w), w[2]));
    for (int w = 0; w < WAYS; w++)
      look(2'b10, 2, 12'h100 + 12'(w), 2'd0, (w == 5) ? "R4" : "R3");
    look(2'b01, 2, 12'h104, 2'd3, "R10");      // release hit: no flag
    look(2'b10, 2, 12'h1FF, 2'd0, "R10");      // snoop miss: no flag

    // R7/R8: line held upstream under alias 1
    do_write(9, 3, 12'h2A3, mk(2'b11, 1'b1, 1'b1, 2'd1, 1'b1, 2'd2, 1'b0));
    do_write(9, 6, 12'h2A6, mk(2'b10, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1));
    look(2'b00, 9, 12'h2A3, 2'd2, "R7");
    do_lookup(2'b00, 9, 12'h2A3, 2'd2, "R8", st);
    chk(st == 1, "R8", "same-set lookup held during alias update", 64'(st), 1);
    look(2'b00, 9, 12'h2A3, 2'd2, "R8");       // alias now 2: no probe
    look(2'b01, 9, 12'h2A3, 2'd0, "R9");       // release: no probe
    look(2'b10, 9, 12'h2A3, 2'd3, "R9");       // snoop: no probe
    look(2'b00, 9, 12'h2A6, 2'd3, "R9");       // upstream-holds clear: no probe
    look(2'b11, 9, 12'h2A3, 2'd1, "R9");       // code 11 acts as snoop
    look(2'b00, 9, 12'h2A3, 2'd0, "R7");       // new conflict: probe alias 2
    look(2'b00, 4, 12'h2A3, 2'd1, "R7");       // other set, miss

    // R6: concurrent write and lookup
    both(11, 11, 12'h3C0, mk(2'b01, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0), 1'b0);
    both(12, 13, 12'h3C1, mk(2'b11, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0), 1'b1);
    look(2'b10, 12, 12'h3C1, 2'd0, "R5");

    // R5/R3/R7: varied pattern across sets
    for (int i = 0; i < 48; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31:30] == 2'b00)
        do_write(int'(lcg[11:8]), int'(lcg[14:12]), 12'h400 + 12'(lcg[17:16]),
                 mk(lcg[19:18], lcg[20], lcg[21], lcg[23:22], lcg[24], lcg[26:25], lcg[27]));
      else
        look(lcg[29:28] == 2'b11 ? 2'b00 : lcg[29:28], int'(lcg[11:8]),
             12'h400 + 12'(lcg[17:16]), lcg[23:22], "R3");
    end

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "results outstanding", 64'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule